// File: doc/BRIEF.md
# Input Sampling Frequency Estimator

This block works out the sampling rate of an incoming audio stream. It counts cycles of a fixed 24.576 MHz crystal reference clock over eight periods of the stream's frame clock. It then sorts the count into one of eight standard rate codes, or into an out-of-range code. The frame clock arrives from another clock domain, so the block first synchronizes it into the reference domain. All results are registered in that domain.

A range bit decides which rates may be reported: either the lower group of 32 to 96 kHz, or the upper group of 64 to 192 kHz. A rate that fits a window but lies outside the chosen group reads as out-of-range. The block has two operating modes:

- **Continuous mode** measures without a break and updates the code after every window.
- **Hold mode** measures only while the lock-error flag is high. It keeps the first completed result until the next unlock, which is the next rising edge of the lock-error flag.

If no independent reference oscillator is present, the code is forced to out-of-range.

Top module: `fs_estimator`

## Requirements
- R1: The block counts reference cycles over 8 frame-clock periods. It reports the code whose window contains the count. The nominal count for a rate is 196608000 / rate, rounded. The window is nominal ± floor(nominal/25). The codes are 1=32 kHz, 2=44.1 kHz, 3=48 kHz, 4=64 kHz, 5=88.2 kHz, 6=96 kHz, 7=176.4 kHz and 8=192 kHz. After each completed window, fs_code and fs_valid are updated.
- R2: With range_hi=0, only codes 1 to 6 can be reported. A 192 kHz or 176.4 kHz stream reads 0.
- R3: With range_hi=1, only codes 4 to 8 can be reported. A 32 kHz, 44.1 kHz or 48 kHz stream reads 0.
- R4: A count that lies in no window gives fs_code=0 with fs_valid=1.
- R5: With cont_mode=0, measurement runs only while lock_err=1. The first completed result is then frozen. It does not change when the rate changes, whether lock_err stays high or falls, until lock_err rises again.
- R6: With cont_mode=1, measurement repeats regardless of lock_err. The code follows rate changes within two windows.
- R7: On the first clock edge that sees lock_err rise, fs_valid and fs_code are cleared to 0 and a new measurement starts.
- R8: While osc_present=0, fs_code reads 0 from the clock edge after osc_present is seen low.
- R9: After reset, fs_code=0 and fs_valid=0. fs_valid rises only when a measurement completes.
- R10: With cont_mode=0 and lock_err held at 0, no measurement completes and fs_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed reference clock, 24.576 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Asynchronous frame clock of the audio stream |
| lock_err | input | 1 | Lock-error flag, high while unlocked, synchronous to clk |
| range_hi | input | 1 | 0: 32 to 96 kHz group, 1: 64 to 192 kHz group |
| cont_mode | input | 1 | 1: continuous measurement, 0: hold mode |
| osc_present | input | 1 | High when an independent reference oscillator exists |
| fs_code | output | 4 | Rate code, 0 means out of range |
| fs_valid | output | 1 | A completed measurement is held in fs_code |

## Verification
The hardest case to reach is a frozen hold-mode result while lock_err stays high and the input rate changes. Here the counter must stay idle even though the lock-error condition that normally enables it is still present. The stimulus reaches it by first capturing 44.1 kHz after an unlock edge. It then switches the frame clock to 96 kHz without lowering lock_err and waits more than a full window before checking that the code is unchanged. A seeded random loop in continuous mode mixes rates, ±2% deviations and range settings, so that in-group, cross-group and out-of-range outcomes all occur.

// File: rtl/fs_est_pkg.sv
// Shared definitions for the sampling frequency estimator.
// Assumes rate codes 1..8 in ascending rate order; code 0 means out of range.
package fs_est_pkg;

    localparam int NUM_CODES = 8;
    localparam int CODE_W    = 4;

    typedef enum logic [CODE_W-1:0] {
        FS_NONE  = 4'd0,
        FS_32K   = 4'd1,
        FS_44K1  = 4'd2,
        FS_48K   = 4'd3,
        FS_64K   = 4'd4,
        FS_88K2  = 4'd5,
        FS_96K   = 4'd6,
        FS_176K4 = 4'd7,
        FS_192K  = 4'd8
    } fs_code_e;

    // Nominal sampling rate in Hz for a code
    function automatic longint rate_hz(input int code);
        case (code)
            1:       return 64'd32000;
            2:       return 64'd44100;
            3:       return 64'd48000;
            4:       return 64'd64000;
            5:       return 64'd88200;
            6:       return 64'd96000;
            7:       return 64'd176400;
            default: return 64'd192000;
        endcase
    endfunction

    // Rounded reference-cycle count for a code over a window of frames
    function automatic longint nominal_count(input longint ref_hz, input int frames, input int code);
        longint r;
        r = rate_hz(code);
        return (ref_hz * frames + r / 2) / r;
    endfunction

    // Code belongs to the lower group (32..96 kHz)
    function automatic bit in_low_group(input int code);
        return (code >= 1) && (code <= 6);
    endfunction

    // Code belongs to the upper group (64..192 kHz)
    function automatic bit in_high_group(input int code);
        return (code >= 4) && (code <= 8);
    endfunction

endpackage

// File: rtl/fs_est_edge_sync.sv
// Brings an asynchronous level into the clk domain through a flop chain
// and pulses rise_o for one cycle on each synchronized rising edge.
// Assumes the input is slow compared with clk (at least 4 clk per period).
module fs_est_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    // Metastability chain plus one delay flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], async_i};
            last_q <= chain[STAGES-1];
        end
    end

    assign rise_o = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/fs_est_window.sv
// Counts clk cycles across NUM_FRAMES frame periods. The first edge after
// run_i arms the window; every NUM_FRAMES-th edge after that closes it,
// presents the count with a one-cycle done_o pulse and opens the next one.
// Assumes edge_i is a single-cycle pulse. The count saturates at all ones.
module fs_est_window #(
    parameter int NUM_FRAMES = 8,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             edge_i,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);

    localparam int               FR_W     = $clog2(NUM_FRAMES + 1);
    localparam logic [FR_W-1:0]  LAST_FR  = FR_W'(NUM_FRAMES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic             started;
    logic [FR_W-1:0]  frames;
    logic [CNT_W-1:0] cnt;

    // Window sequencing and cycle counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            frames  <= '0;
            cnt     <= '0;
            done_o  <= 1'b0;
            count_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (!run_i || restart_i) begin
                started <= 1'b0;
                frames  <= '0;
                cnt     <= '0;
            end else if (edge_i && !started) begin
                started <= 1'b1;
                frames  <= '0;
                cnt     <= CNT_ONE;
            end else if (edge_i && frames == LAST_FR) begin
                done_o  <= 1'b1;
                count_o <= cnt;
                frames  <= '0;
                cnt     <= CNT_ONE;
            end else begin
                if (edge_i) frames <= frames + 1'b1;
                if (started && cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
        end
    end

    // A window can only close on a frame edge
    AST_DONE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(edge_i)) else $error("window closed without edge"); // R1

endmodule

// File: rtl/fs_est_classify.sv
// Compares a window count against one tolerance window per rate code and
// returns the matching code, or 0. A parallel bank of constant comparators
// is generated; codes outside the group picked by range_hi_i never match.
// Assumes windows do not overlap for the chosen tolerance.
module fs_est_classify
    import fs_est_pkg::*;
#(
    parameter longint REF_HZ     = 24_576_000,
    parameter int     NUM_FRAMES = 8,
    parameter int     TOL_DIV    = 25,
    parameter int     CNT_W      = 16
) (
    input  logic [CNT_W-1:0]     count_i,
    input  logic                 range_hi_i,
    output logic [NUM_CODES-1:0] match_o,
    output logic [CODE_W-1:0]    code_o
);

    for (genvar i = 1; i <= NUM_CODES; i++) begin : g_win
        localparam longint           NOM   = nominal_count(REF_HZ, NUM_FRAMES, i);
        localparam logic [CNT_W-1:0] LO_C  = CNT_W'(NOM - NOM / TOL_DIV);
        localparam logic [CNT_W-1:0] HI_C  = CNT_W'(NOM + NOM / TOL_DIV);
        localparam bit               OK_LO = in_low_group(i);
        localparam bit               OK_HI = in_high_group(i);

        assign match_o[i-1] = (count_i >= LO_C) && (count_i <= HI_C)
                            && (range_hi_i ? OK_HI : OK_LO);
    end

    // Encode the matching window into its code
    always_comb begin
        code_o = '0;
        for (int k = 0; k < NUM_CODES; k++) begin
            if (match_o[k]) code_o = CODE_W'(k + 1);
        end
    end

endmodule

// File: rtl/fs_estimator.sv
// Sampling frequency estimator top. Runs the window counter on the crystal
// reference clock, classifies each completed count and registers the code.
// Hold mode measures during lock_err and freezes the first result until the
// next rising edge of lock_err; continuous mode updates after every window.
// Assumes lock_err, range_hi, cont_mode and osc_present are clk-synchronous.
module fs_estimator
    import fs_est_pkg::*;
#(
    parameter longint REF_HZ      = 24_576_000,
    parameter int     NUM_FRAMES  = 8,
    parameter int     TOL_DIV     = 25,
    parameter int     CNT_W       = 16,
    parameter int     SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_clk,
    input  logic              lock_err,
    input  logic              range_hi,
    input  logic              cont_mode,
    input  logic              osc_present,
    output logic [CODE_W-1:0] fs_code,
    output logic              fs_valid
);

    logic                 frame_rise;
    logic                 lock_q;
    logic                 unlock_rise;
    logic                 frozen;
    logic                 run;
    logic                 meas_done;
    logic [CNT_W-1:0]     meas_cnt;
    logic [NUM_CODES-1:0] match;
    logic [CODE_W-1:0]    cls_code;

    assign unlock_rise = lock_err & ~lock_q;
    assign run         = cont_mode | (lock_err & ~frozen);

    fs_est_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (frame_clk),
        .rise_o  (frame_rise)
    );

    fs_est_window #(
        .NUM_FRAMES (NUM_FRAMES),
        .CNT_W      (CNT_W)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (unlock_rise),
        .edge_i    (frame_rise),
        .done_o    (meas_done),
        .count_o   (meas_cnt)
    );

    fs_est_classify #(
        .REF_HZ     (REF_HZ),
        .NUM_FRAMES (NUM_FRAMES),
        .TOL_DIV    (TOL_DIV),
        .CNT_W      (CNT_W)
    ) u_classify (
        .count_i    (meas_cnt),
        .range_hi_i (range_hi),
        .match_o    (match),
        .code_o     (cls_code)
    );

    // Delay of lock_err for unlock edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_err;
    end

    // Result register, hold-mode freeze and unlock clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_code  <= FS_NONE;
            fs_valid <= 1'b0;
            frozen   <= 1'b0;
        end else if (unlock_rise) begin
            fs_code  <= FS_NONE;
            fs_valid <= 1'b0;
            frozen   <= 1'b0;
        end else begin
            if (meas_done) begin
                fs_code  <= cls_code;
                fs_valid <= 1'b1;
                frozen   <= ~cont_mode;
            end
            if (!osc_present) fs_code <= FS_NONE;
        end
    end

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)) else $error("count matched two windows"); // R1
    AST_LOW_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(meas_done) && !$past(range_hi) |-> fs_code <= 4'd6) else $error("upper code in lower group"); // R2
    AST_HIGH_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(meas_done) && $past(range_hi) |-> (fs_code == 4'd0 || fs_code >= 4'd4)) else $error("lower code in upper group"); // R3
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !cont_mode && osc_present && !$rose(lock_err) |=> $stable(fs_code)) else $error("held code changed"); // R5
    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_err) |=> !fs_valid && fs_code == 4'd0) else $error("unlock did not clear"); // R7
    AST_NO_OSC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(osc_present) |-> fs_code == 4'd0) else $error("code without oscillator"); // R8
    AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_valid) |-> $past(meas_done)) else $error("valid without measurement"); // R9
    AST_IDLE_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_mode && !lock_err |=> !meas_done) else $error("hold mode measured while locked"); // R10

endmodule

// File: tb/fs_estimator_tb.sv
`timescale 1ps/1ps
module fs_estimator_tb_top;

    localparam int CLK_PS   = 40690;
    localparam int WD_LIMIT = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       lock_err = 1'b0;
    logic       range_hi = 1'b0;
    logic       cont_mode = 1'b0;
    logic       osc_present = 1'b1;
    logic [3:0] fs_code;
    logic       fs_valid;

    int  checks = 0;
    int  errors = 0;
    int  fr_half_ps = 10416667;
    real cur_rate = 48000.0;

    fs_estimator dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_clk   (frame_clk),
        .lock_err    (lock_err),
        .range_hi    (range_hi),
        .cont_mode   (cont_mode),
        .osc_present (osc_present),
        .fs_code     (fs_code),
        .fs_valid    (fs_valid)
    );

    always #(CLK_PS / 2) clk = ~clk;

    always begin
        #(fr_half_ps);
        frame_clk = ~frame_clk;
    end

    function automatic real std_rate(input int c);
        case (c)
            1: return 32000.0;
            2: return 44100.0;
            3: return 48000.0;
            4: return 64000.0;
            5: return 88200.0;
            6: return 96000.0;
            7: return 176400.0;
            default: return 192000.0;
        endcase
    endfunction

    // Expected code from the rate, group and oscillator flag (R1 to R4, R8)
    function automatic int exp_code(input real rate, input bit hi, input bit osc);
        real cnt;
        real nom;
        real tol;
        int  res;
        res = 0;
        cnt = 8.0 * (1.0e12 / real'(CLK_PS)) / rate;
        if (!osc) return 0;
        for (int c = 1; c <= 8; c++) begin
            nom = $floor(8.0 * 24576000.0 / std_rate(c) + 0.5);
            tol = $floor(nom / 25.0);
            if (cnt >= nom - tol && cnt <= nom + tol && (hi ? (c >= 4) : (c <= 6)))
                res = c;
        end
        return res;
    endfunction

    function automatic int period_clks(input real rate);
        return int'(1.0e12 / rate / real'(CLK_PS)) + 1;
    endfunction

    task automatic set_rate(input real rate);
        cur_rate   = rate;
        fr_half_ps = int'(1.0e12 / (2.0 * rate));
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_cont();
        wait_clks(18 * period_clks(cur_rate) + 900);
    endtask

    task automatic settle_hold();
        wait_clks(10 * period_clks(cur_rate) + 900);
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int  c;
        int  dev;
        bit  hi;
        real r;
        void'($urandom(32'h5EED_0F5E));
        set_rate(48000.0);
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(1);
        chk("R9 reset code", int'(fs_code), 0);
        chk("R9 reset valid", int'(fs_valid), 0);

        // Hold mode, locked from reset: nothing measured
        settle_hold();
        chk("R10 idle while locked", int'(fs_valid), 0);

        // Hold mode: measure during lock error
        lock_err = 1'b1;
        settle_hold();
        chk("R5 hold capture 48k", int'(fs_code), 3);
        chk("R9 valid after measure", int'(fs_valid), 1);

        // Locked again, rate changes: result frozen
        lock_err = 1'b0;
        set_rate(44100.0);
        settle_hold();
        chk("R5 frozen while locked", int'(fs_code), 3);

        // Unlock edge clears on the next edge
        lock_err = 1'b1;
        wait_clks(1);
        chk("R7 unlock clears valid", int'(fs_valid), 0);
        chk("R7 unlock clears code", int'(fs_code), 0);
        settle_hold();
        chk("R5 remeasure 44.1k", int'(fs_code), 2);

        // Rate changes while still unlocked: stays frozen
        set_rate(96000.0);
        settle_hold();
        chk("R5 frozen while unlocked", int'(fs_code), 2);

        // Continuous mode, seeded random rates and groups
        lock_err  = 1'b0;
        cont_mode = 1'b1;
        for (int it = 0; it < 8; it++) begin
            c   = 1 + int'($urandom % 8);
            dev = int'($urandom % 41) - 20;
            hi  = 1'($urandom % 2);
            r   = std_rate(c) * (1000.0 + real'(dev)) / 1000.0;
            range_hi = hi;
            set_rate(r);
            settle_cont();
            chk("R6 continuous random code", int'(fs_code), exp_code(r, hi, 1'b1));
            chk("R6 continuous valid", int'(fs_valid), 1);
        end

        // Directed group and range corners
        range_hi = 1'b0;
        set_rate(192000.0);
        settle_cont();
        chk("R2 192k in lower group", int'(fs_code), exp_code(192000.0, 1'b0, 1'b1));
        range_hi = 1'b1;
        set_rate(32000.0);
        settle_cont();
        chk("R3 32k in upper group", int'(fs_code), 0);
        set_rate(120000.0);
        settle_cont();
        chk("R4 no window", int'(fs_code), 0);
        chk("R4 valid with no window", int'(fs_valid), 1);
        range_hi = 1'b0;
        set_rate(48000.0);
        settle_cont();
        chk("R1 48k lower group", int'(fs_code), 3);

        // Oscillator absent
        osc_present = 1'b0;
        wait_clks(2);
        chk("R8 no oscillator immediate", int'(fs_code), 0);
        settle_cont();
        chk("R8 no oscillator after windows", int'(fs_code), 0);
        osc_present = 1'b1;
        settle_cont();
        chk("R8 oscillator restored", int'(fs_code), 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule